// File: doc/BRIEF.md
# Fixed-Point Scanline Vertical Scaler

This block stretches a stored bitmap to any height over one display pass. It keeps a row pointer in fixed point, with an integer part and a fraction part. A frame-start pulse sets the pointer to zero and arms a new pass. Each line-advance pulse closes one scan line and adds a programmable fractional step to the pointer. The fraction's carry ripples into the integer part.

The integer part of the pointer addresses an internal row table. The fetched row pattern is registered and drives two identical playfield outputs. Because the step is fractional, the final height of the image scales smoothly: it is inversely proportional to the step, not tied to whole multiples of the bitmap's row count. After the last line of a pass, a done flag rises and the pointer freezes until the next frame start.

Top module: `vscale_top`

## Requirements
- R1: While reset is asserted, `row_addr` is 0, both playfield outputs are 0 and `frame_done` is 0.
- R2: A `frame_start` pulse clears the pointer (integer and fraction) and clears `frame_done`. From the next cycle, `row_addr` reads 0.
- R3: During a pass, each accepted `line_stb` adds `step` to the pointer's fraction and carries into the integer part. The new integer part appears on `row_addr` in the cycle after the strobe. With the default 8-bit fraction, a step of 0x80 moves the pointer by one half row.
- R4: The row table holds, at address a, the pattern a XOR `PAT_MASK` (default 0x5A). Both playfield outputs carry the table entry for the `row_addr` of the previous cycle and are always equal.
- R5: A pass holds exactly `LINES` (default 192) accepted strobes. The last strobe does not move the pointer. `frame_done` rises in the cycle after that strobe.
- R6: While `frame_done` is high, `line_stb` has no effect: `row_addr`, the playfield outputs and `frame_done` stay unchanged until the next `frame_start`.
- R7: When `frame_start` and `line_stb` are high in the same cycle, the frame start wins. The pointer and the line count are both cleared, and that strobe is not counted.
- R8: After reset and before the first `frame_start`, line strobes are ignored. `row_addr` stays 0 and `frame_done` stays 0.
- R9: At the end of a pass, `row_addr` equals floor((LINES-1) * step / 2^FRAC_W). This means the displayed height varies inversely with the step.
- R10: During a pass, the integer part never wraps. `row_addr` never decreases from one accepted strobe to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse: clear the pointer and arm a pass |
| line_stb | input | 1 | One-cycle pulse at the end of each scan line |
| step | input | FRAC_W | Fractional pointer increment per line |
| row_addr | output | INT_W | Integer part of the pointer, the row table address |
| pf_left | output | PAT_W | Registered row pattern, first playfield copy |
| pf_right | output | PAT_W | Registered row pattern, second playfield copy |
| frame_done | output | 1 | High from the end of a pass until the next frame start |

## Verification
The frame-start clear and the line advance can fall in the same cycle. The bench provokes this by raising both pulses together partway through a running pass. The result is judged from what follows. `row_addr` must read 0 at once. It must reach one half row only after one further strobe. `frame_done` must rise only after a full `LINES` strobes counted from the collision, so the colliding strobe is shown not to count.

// File: rtl/vscale_pkg.sv
`timescale 1ns/1ps
package vscale_pkg;

   typedef enum logic [1:0] {
      PASS_IDLE = 2'd0,
      PASS_RUN  = 2'd1,
      PASS_DONE = 2'd2
   } pass_state_t;

   // Worst-case integer reach of a pass: (lines-1) steps of the largest fraction.
   function automatic longint unsigned max_reach(input int lines, input int frac_w);
      longint unsigned top_step;
      top_step = (longint'(1) << frac_w) - 1;
      return (longint'(lines - 1) * top_step) >> frac_w;
   endfunction

endpackage

// File: rtl/vscale_frac_add.sv
`timescale 1ns/1ps
module vscale_frac_add #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 8
) (
   input  logic [INT_W-1:0]  cur_int,
   input  logic [FRAC_W-1:0] cur_frac,
   input  logic [FRAC_W-1:0] inc,
   output logic [INT_W-1:0]  nxt_int,
   output logic [FRAC_W-1:0] nxt_frac
);

   localparam int SLICE_W  = 8;
   localparam bit SLICED   = (FRAC_W % SLICE_W) == 0;
   localparam int N_SLICES = SLICED ? FRAC_W / SLICE_W : 1;

   logic frac_carry;

   generate
      if (SLICED) begin : g_sliced
         // Byte-wide slices with a rippled carry, one per fraction byte.
         logic [N_SLICES:0] cy;
         assign cy[0] = 1'b0;
         for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
            logic [SLICE_W:0] part;
            assign part = {1'b0, cur_frac[s*SLICE_W +: SLICE_W]}
                        + {1'b0, inc[s*SLICE_W +: SLICE_W]}
                        + {{SLICE_W{1'b0}}, cy[s]};
            assign nxt_frac[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign cy[s+1] = part[SLICE_W];
         end
         assign frac_carry = cy[N_SLICES];
      end else begin : g_flat
         logic [FRAC_W:0] whole;
         assign whole      = {1'b0, cur_frac} + {1'b0, inc};
         assign nxt_frac   = whole[FRAC_W-1:0];
         assign frac_carry = whole[FRAC_W];
      end
   endgenerate

   assign nxt_int = cur_int + {{(INT_W-1){1'b0}}, frac_carry};

endmodule

// File: rtl/vscale_ptr_reg.sv
`timescale 1ns/1ps
module vscale_ptr_reg #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [FRAC_W-1:0] step,
   output logic [INT_W-1:0]  ptr_int,
   output logic [FRAC_W-1:0] ptr_frac
);

   logic [INT_W-1:0]  sum_int;
   logic [FRAC_W-1:0] sum_frac;

   vscale_frac_add #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W)
   ) u_add (
      .cur_int  (ptr_int),
      .cur_frac (ptr_frac),
      .inc      (step),
      .nxt_int  (sum_int),
      .nxt_frac (sum_frac)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_int  <= '0;
         ptr_frac <= '0;
      end else if (clear) begin
         ptr_int  <= '0;
         ptr_frac <= '0;
      end else if (advance) begin
         ptr_int  <= sum_int;
         ptr_frac <= sum_frac;
      end
   end

endmodule

// File: rtl/vscale_line_ctl.sv
`timescale 1ns/1ps
module vscale_line_ctl
   import vscale_pkg::*;
#(
   parameter int LINES = 192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic line_stb,
   output logic clear,
   output logic advance,
   output logic done
);

   localparam int CNT_W = $clog2(LINES + 1);

   pass_state_t      state;
   logic [CNT_W-1:0] line_cnt;
   logic             accept;
   logic             last_line;

   assign accept    = (state == PASS_RUN) && line_stb && !frame_start;
   assign last_line = line_cnt == CNT_W'(LINES - 1);
   assign clear     = frame_start;
   assign advance   = accept && !last_line;
   assign done      = state == PASS_DONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PASS_IDLE;
         line_cnt <= '0;
      end else if (frame_start) begin
         state    <= PASS_RUN;
         line_cnt <= '0;
      end else if (accept) begin
         line_cnt <= line_cnt + 1'b1;
         if (last_line) begin
            state <= PASS_DONE;
         end
      end
   end

endmodule

// File: rtl/vscale_row_rom.sv
`timescale 1ns/1ps
module vscale_row_rom #(
   parameter int               ADDR_W   = 8,
   parameter int               PAT_W    = 8,
   parameter logic [PAT_W-1:0] PAT_MASK = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [PAT_W-1:0]  pat_q
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [PAT_W-1:0] tbl [DEPTH];

   generate
      for (genvar a = 0; a < DEPTH; a++) begin : g_row
         assign tbl[a] = PAT_W'(a) ^ PAT_MASK;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q <= '0;
      end else begin
         pat_q <= tbl[addr];
      end
   end

endmodule

// File: rtl/vscale_top.sv
`timescale 1ns/1ps
module vscale_top
   import vscale_pkg::*;
#(
   parameter int               INT_W    = 8,
   parameter int               FRAC_W   = 8,
   parameter int               LINES    = 192,
   parameter int               PAT_W    = 8,
   parameter logic [PAT_W-1:0] PAT_MASK = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_stb,
   input  logic [FRAC_W-1:0] step,
   output logic [INT_W-1:0]  row_addr,
   output logic [PAT_W-1:0]  pf_left,
   output logic [PAT_W-1:0]  pf_right,
   output logic              frame_done
);

   localparam longint unsigned REACH = max_reach(LINES, FRAC_W);

   generate
      if (INT_W < 1 || INT_W > 10) begin : g_bad_int
         $error("vscale_top: INT_W must lie in 1..10");
      end
      if (FRAC_W < 1 || FRAC_W > 32) begin : g_bad_frac
         $error("vscale_top: FRAC_W must lie in 1..32");
      end
      if (LINES < 2) begin : g_bad_lines
         $error("vscale_top: LINES must be at least 2");
      end
      if (REACH >= (longint'(1) << INT_W)) begin : g_bad_reach
         $error("vscale_top: integer part too narrow for a full pass");
      end
   endgenerate

   logic             clr;
   logic             adv;
   logic [FRAC_W-1:0] frac_q;
   logic [PAT_W-1:0]  pat;

   vscale_line_ctl #(
      .LINES (LINES)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_stb    (line_stb),
      .clear       (clr),
      .advance     (adv),
      .done        (frame_done)
   );

   vscale_ptr_reg #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clr),
      .advance  (adv),
      .step     (step),
      .ptr_int  (row_addr),
      .ptr_frac (frac_q)
   );

   vscale_row_rom #(
      .ADDR_W   (INT_W),
      .PAT_W    (PAT_W),
      .PAT_MASK (PAT_MASK)
   ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (row_addr),
      .pat_q (pat)
   );

   assign pf_left  = pat;
   assign pf_right = pat;

   logic unused_frac;
   assign unused_frac = ^frac_q;

endmodule

// File: rtl/vscale_chk.sv
`timescale 1ns/1ps
module vscale_chk #(
   parameter int               INT_W    = 8,
   parameter int               LINES    = 192,
   parameter int               PAT_W    = 8,
   parameter logic [PAT_W-1:0] PAT_MASK = 8'h5A
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             line_stb,
   input logic [INT_W-1:0] row_addr,
   input logic [PAT_W-1:0] pf_left,
   input logic [PAT_W-1:0] pf_right,
   input logic             frame_done
);

   localparam int CW = $clog2(LINES + 1);

   logic          warm;
   logic          run;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm <= 1'b0;
         run  <= 1'b0;
         cnt  <= '0;
      end else begin
         warm <= 1'b1;
         if (frame_start) begin
            run <= 1'b1;
            cnt <= '0;
         end else if (run && line_stb) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(LINES - 1)) run <= 1'b0;
         end
      end
   end

   assert_pf_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pf_left == pf_right);

   assert_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> pf_left == (PAT_W'($past(row_addr)) ^ PAT_MASK));

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (row_addr == '0) && !frame_done);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_start) |=> $stable(row_addr) && frame_done);

   assert_done_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_done) |-> cnt == CW'(LINES));

   assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb && !frame_start && !frame_done) |=> row_addr >= $past(row_addr));

endmodule

bind vscale_top vscale_chk #(
   .INT_W    (INT_W),
   .LINES    (LINES),
   .PAT_W    (PAT_W),
   .PAT_MASK (PAT_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .line_stb    (line_stb),
   .row_addr    (row_addr),
   .pf_left     (pf_left),
   .pf_right    (pf_right),
   .frame_done  (frame_done)
);

// File: tb/tb_vscale_top.sv
`timescale 1ns/1ps
module tb_vscale_top;

   localparam int LINES = 192;
   localparam logic [7:0] MASK = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs = 1'b0;
   logic       ls = 1'b0;
   logic [7:0] step = 8'h00;
   logic [7:0] row_addr;
   logic [7:0] pf_left;
   logic [7:0] pf_right;
   logic       frame_done;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   vscale_top dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (fs),
      .line_stb    (ls),
      .step        (step),
      .row_addr    (row_addr),
      .pf_left     (pf_left),
      .pf_right    (pf_right),
      .frame_done  (frame_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive one cycle of pulses from a falling edge; returns at the next falling edge.
   task automatic tick(input logic f, input logic l);
      fs = f;
      ls = l;
      @(negedge clk);
      fs = 1'b0;
      ls = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(row_addr == 0, "R1 row_addr", row_addr, 0);
      check(pf_left == 0 && pf_right == 0, "R1 playfield", pf_left, 0);
      check(frame_done == 0, "R1 frame_done", frame_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(pf_left == int'(MASK), "R4 idle fetch of row 0", pf_left, MASK);
   endtask

   task automatic t_pre_frame();
      step = 8'h80;
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
      check(row_addr == 0, "R8 strobes before frame start", row_addr, 0);
      check(frame_done == 0, "R8 done before frame start", frame_done, 0);
   endtask

   task automatic t_steps();
      step = 8'h80;
      tick(1'b1, 1'b0);
      check(row_addr == 0 && frame_done == 0, "R2 cleared", row_addr, 0);
      tick(1'b0, 1'b1);
      check(row_addr == 0, "R3 half step", row_addr, 0);
      tick(1'b0, 1'b1);
      check(row_addr == 1, "R3 carry into integer", row_addr, 1);
      @(negedge clk);
      check(pf_left == int'(8'd1 ^ MASK), "R4 pattern row 1", pf_left, 8'd1 ^ MASK);
      check(pf_right == pf_left, "R4 copies equal", pf_right, pf_left);
      step = 8'hC0;
      tick(1'b0, 1'b1);
      check(row_addr == 1, "R3 pointer 1.75", row_addr, 1);
      tick(1'b0, 1'b1);
      check(row_addr == 2, "R3 pointer 2.5", row_addr, 2);
      @(negedge clk);
      check(pf_left == int'(8'd2 ^ MASK), "R4 pattern row 2", pf_left, 8'd2 ^ MASK);
   endtask

   // A full pass: per-line pointer model, done timing and final row.
   task automatic t_pass(input logic [7:0] s, input bit started);
      int ptr;
      int bad;
      step = s;
      if (!started) tick(1'b1, 1'b0);
      ptr = 0;
      bad = 0;
      for (int i = 0; i < LINES; i++) begin
         tick(1'b0, 1'b1);
         if (i < LINES - 1) ptr += s;
         if (row_addr != (ptr >> 8)) bad++;
         if (i == LINES - 2)
            check(frame_done == 0, "R5 done not early", frame_done, 0);
      end
      check(bad == 0, "R3 per-line pointer", bad, 0);
      check(frame_done == 1, "R5 done after last line", frame_done, 1);
      check(row_addr == ((LINES - 1) * s) >> 8, "R9 final row",
            row_addr, ((LINES - 1) * s) >> 8);
   endtask

   task automatic t_after_done();
      logic [7:0] held_row;
      logic [7:0] held_pf;
      held_row = row_addr;
      @(negedge clk);
      held_pf = pf_left;
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
      check(row_addr == held_row, "R6 row held", row_addr, held_row);
      check(pf_left == held_pf, "R6 pattern held", pf_left, held_pf);
      check(frame_done == 1, "R6 done held", frame_done, 1);
      tick(1'b1, 1'b0);
      check(frame_done == 0 && row_addr == 0, "R2 new frame clears done", frame_done, 0);
   endtask

   task automatic t_collide();
      int prev;
      step = 8'h80;
      prev = 0;
      for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
      check(row_addr == 2, "R3 mid-pass before collision", row_addr, 2);
      tick(1'b1, 1'b1);
      check(row_addr == 0, "R7 frame start wins", row_addr, 0);
      tick(1'b0, 1'b1);
      check(row_addr == 0, "R7 fraction cleared", row_addr, 0);
      tick(1'b0, 1'b1);
      check(row_addr == 1, "R7 restart count", row_addr, 1);
      for (int i = 2; i < LINES - 1; i++) begin
         prev = row_addr;
         tick(1'b0, 1'b1);
         if (row_addr < prev) check(0, "R10 monotonic", row_addr, prev);
      end
      check(frame_done == 0, "R7 colliding strobe not counted", frame_done, 0);
      tick(1'b0, 1'b1);
      check(frame_done == 1, "R7 done after full count", frame_done, 1);
   endtask

   initial begin
      t_reset();
      t_pre_frame();
      t_steps();
      tick(1'b1, 1'b0);
      t_pass(8'h40, 1'b1);
      t_after_done();
      t_pass(8'hFF, 1'b1);
      t_pass(8'h00, 1'b0);
      t_pass(8'hAB, 1'b0);
      tick(1'b1, 1'b0);
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule